// File: doc/BRIEF.md
# Divided-Clock Phase/Frequency Detector Core

This block is the digital heart of a frequency synthesizer loop. It counts edges from a VCO and divides them by a programmable ratio N. It counts edges from a crystal and divides them by a fixed ratio of 32, which gives the comparison reference. A tri-state phase/frequency detector then compares the falling edges of the two divided waveforms. Its UP and DOWN outputs steer an external charge pump. A separate high-impedance flag tells that pump when to float.

Everything runs on one fast sampling clock `clk`. The two source clocks arrive as single-cycle strobes, `vco_tick` and `xtal_tick`, which are already synchronized to `clk`. Each divider therefore advances only on a cycle with its strobe, so the whole divider chain is synchronous and has no ripple stage. Two test bits, written here as `t1` and `t0` and read together as `{t1,t0}`, pick one of four modes:
- `00`: normal operation.
- `10`: export the divided waveforms on two port pins.
- `01`: force the pump to high impedance.
- `11`: replace the internal divided waveforms with the two port inputs at the detector.

Top module: `pfd_divider_core`

## Requirements
- R1: During and after a synchronous reset (`rst` high), the outputs are as follows:
  - `up_o`, `dn_o`, `port_p0_o` and `port_p1_o` are 0.
  - `cp_hiz_o` is 1.
  - `cy_o` and `fref_o` are 1.
- R2: With a ratio N, `cy_o` repeats every N `vco_tick` strobes. It rises on the strobe that wraps the count to 0, stays high for floor(N/2) strobes, then stays low for the rest of the period.
- R3: A ratio below 256 on `n_ratio` is used as 256.
- R4: A new `n_ratio` is captured only on the strobe that ends the current period. The period in progress keeps its old length, and the next period has the new length.
- R5: `fref_o` repeats every 32 `xtal_tick` strobes. It is high for 16 strobes and low for 16.
- R6: When the detector's Cy input falls before its reference input falls, `up_o` goes high the cycle after the Cy fall. It goes low the cycle after the reference fall, so it is high for as many cycles as the edges are apart.
- R7: When the reference falls first, `dn_o` behaves in the same way with the roles swapped.
- R8: `up_o` and `dn_o` are never both 1. When both falls land in the same cycle, or when the second fall arrives, both outputs return to 0.
- R9: `cp_hiz_o` is registered alongside `up_o` and `dn_o`. It is 1 when neither of them is 1, and it is 1 one cycle after any cycle with `t0`=1, whatever the detector does.
- R10: In mode `{t1,t0}`=10, `port_p0_o` and `port_p1_o` carry `fref_o` and `cy_o` delayed by one `clk` cycle. In every other mode both port outputs are 0.
- R11: In mode 11, the detector takes its Cy input from `port_i1` and its reference input from `port_i0`, and the internal dividers have no effect on `up_o` or `dn_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_tick | input | 1 | One-cycle strobe per VCO edge |
| xtal_tick | input | 1 | One-cycle strobe per crystal edge |
| n_ratio | input | 15 | VCO division ratio N |
| t1 | input | 1 | Test bit 1 (export/inject select) |
| t0 | input | 1 | Test bit 0 (pump float / inject select) |
| port_i1 | input | 1 | Port input used as Cy in mode 11 |
| port_i0 | input | 1 | Port input used as reference in mode 11 |
| up_o | output | 1 | Pump source request |
| dn_o | output | 1 | Pump sink request |
| cp_hiz_o | output | 1 | Pump high-impedance flag |
| cy_o | output | 1 | Divided VCO waveform |
| fref_o | output | 1 | Divided crystal reference |
| port_p0_o | output | 1 | Port pin 0 drive (reference in mode 10) |
| port_p1_o | output | 1 | Port pin 1 drive (Cy in mode 10) |

## Verification
The bench changes N in the middle of a period and measures the two periods that follow. A design that reloads N too early would produce a shortened or stretched period that matches neither the old ratio nor the new one. It programs a ratio below the floor and expects a 256-strobe period; an unclamped divider would run too fast. In inject mode it drives lead, lag and coincident falls on the port inputs and counts the UP and DOWN cycles. A detector with the polarity swapped, an off-by-one pulse width, or a spurious pulse on coincident edges shows up directly in those counts. Meanwhile a behavioural model, compared on every cycle, catches a `t0` that fails to float the pump and port pins that leak in the wrong mode.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Test mode encoding is {t1, t0}
  typedef enum logic [1:0] {
    TM_NORMAL = 2'b00,
    TM_HIZ    = 2'b01,
    TM_EXPORT = 2'b10,
    TM_INJECT = 2'b11
  } test_mode_e;

  function automatic test_mode_e decode_mode(input logic t1, input logic t0);
    return test_mode_e'({t1, t0});
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int W         = 15,
  parameter int MIN_RATIO = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         div_o
);
  localparam logic [W-1:0] FLOOR = W'(MIN_RATIO);

  logic [W-1:0] cnt_q, ratio_q, ratio_safe, cnt_inc;
  logic         wrap;

  assign ratio_safe = (ratio_i < FLOOR) ? FLOOR : ratio_i;
  assign cnt_inc    = cnt_q + 1'b1;
  assign wrap       = (cnt_q == ratio_q - 1'b1);

  // Ratio is captured only at terminal count so no period is cut short
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= ratio_safe;
      div_o   <= 1'b1;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q   <= '0;
        ratio_q <= ratio_safe;
        div_o   <= 1'b1;
      end else begin
        cnt_q   <= cnt_inc;
        div_o   <= (cnt_inc < (ratio_q >> 1));
      end
    end
  end

  assert_ratio_floor_R3: assert property (@(posedge clk) disable iff (rst)
    ratio_q >= FLOOR);

  assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && wrap) |=> $stable(ratio_q));

  assert_fall_at_half_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(div_o) |-> (cnt_q == (ratio_q >> 1)));
endmodule

// File: rtl/edge_pfd.sv
module edge_pfd (
  input  logic clk,
  input  logic rst,
  input  logic cy_i,
  input  logic ref_i,
  input  logic hiz_force_i,
  output logic up_o,
  output logic dn_o,
  output logic hiz_o
);
  logic cy_prev, ref_prev;
  logic cy_fall, ref_fall;
  logic up_set, dn_set, clear;

  assign cy_fall  = cy_prev & ~cy_i;
  assign ref_fall = ref_prev & ~ref_i;
  assign up_set   = up_o | cy_fall;
  assign dn_set   = dn_o | ref_fall;
  assign clear    = up_set & dn_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      cy_prev  <= 1'b0;
      ref_prev <= 1'b0;
      up_o     <= 1'b0;
      dn_o     <= 1'b0;
      hiz_o    <= 1'b1;
    end else begin
      cy_prev  <= cy_i;
      ref_prev <= ref_i;
      up_o     <= up_set & ~clear;
      dn_o     <= dn_set & ~clear;
      hiz_o    <= hiz_force_i | clear | ~(up_set | dn_set);
    end
  end

  assert_never_both_R8: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o));

  assert_force_float_R9: assert property (@(posedge clk) disable iff (rst)
    hiz_force_i |=> hiz_o);

  assert_up_after_cy_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(up_o) |-> $past(cy_prev && !cy_i));

  assert_dn_after_ref_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_o) |-> $past(ref_prev && !ref_i));
endmodule

// File: rtl/pfd_divider_core.sv
module pfd_divider_core
  import pfd_pkg::*;
#(
  parameter int N_W     = 15,
  parameter int N_MIN   = 256,
  parameter int REF_DIV = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vco_tick,
  input  logic           xtal_tick,
  input  logic [N_W-1:0] n_ratio,
  input  logic           t1,
  input  logic           t0,
  input  logic           port_i1,
  input  logic           port_i0,
  output logic           up_o,
  output logic           dn_o,
  output logic           cp_hiz_o,
  output logic           cy_o,
  output logic           fref_o,
  output logic           port_p0_o,
  output logic           port_p1_o
);
  localparam int               REF_W     = $clog2(REF_DIV) + 1;
  localparam logic [REF_W-1:0] REF_RATIO = REF_W'(REF_DIV);

  test_mode_e mode;
  logic       cy_int, fref_int, cy_pd, ref_pd;

  assign mode = decode_mode(t1, t0);

  tick_divider #(.W(N_W), .MIN_RATIO(N_MIN)) u_vco_div (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (vco_tick),
    .ratio_i (n_ratio),
    .div_o   (cy_int)
  );

  tick_divider #(.W(REF_W), .MIN_RATIO(2)) u_ref_div (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (xtal_tick),
    .ratio_i (REF_RATIO),
    .div_o   (fref_int)
  );

  // Inject mode swaps the detector inputs for the port inputs
  assign cy_pd  = (mode == TM_INJECT) ? port_i1 : cy_int;
  assign ref_pd = (mode == TM_INJECT) ? port_i0 : fref_int;

  edge_pfd u_pfd (
    .clk         (clk),
    .rst         (rst),
    .cy_i        (cy_pd),
    .ref_i       (ref_pd),
    .hiz_force_i (t0),
    .up_o        (up_o),
    .dn_o        (dn_o),
    .hiz_o       (cp_hiz_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      port_p0_o <= 1'b0;
      port_p1_o <= 1'b0;
    end else begin
      port_p0_o <= (mode == TM_EXPORT) & fref_int;
      port_p1_o <= (mode == TM_EXPORT) & cy_int;
    end
  end

  assign cy_o   = cy_int;
  assign fref_o = fref_int;

  assert_ports_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (mode != TM_EXPORT) |=> (!port_p0_o && !port_p1_o));

  assert_port_follows_cy_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_EXPORT) |=> (port_p1_o == $past(cy_int)));
endmodule

// File: tb/sim_pfd_divider_core.sv
module sim_pfd_divider_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vt = 1'b0, xt = 1'b0;
  logic [14:0] n_in = 15'd300;
  logic        t1 = 1'b0, t0 = 1'b0, i1 = 1'b1, i0 = 1'b1;
  logic        up, dn, hiz, cy, fref, p0, p1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_divider_core u0 (
    .clk(clk), .rst(rst), .vco_tick(vt), .xtal_tick(xt), .n_ratio(n_in),
    .t1(t1), .t0(t0), .port_i1(i1), .port_i0(i0),
    .up_o(up), .dn_o(dn), .cp_hiz_o(hiz), .cy_o(cy), .fref_o(fref),
    .port_p0_o(p0), .port_p1_o(p1)
  );

  int  tests = 0, fails = 0, cyc = 0;
  int  vper = 1, xper = 1;
  int  upcnt = 0, dncnt = 0, drivecnt = 0;
  int  rises[$];
  bit  last_cy = 1'b1;
  bit  done = 1'b0;

  // Behavioural reference state
  int  m_cnt, m_ratio, m_rcnt;
  bit  m_cy, m_fref, m_pc, m_pr, m_up, m_dn, m_hiz, m_p0, m_p1;

  function automatic int clampn(input int n);
    return (n < 256) ? 256 : n;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic model_update();
    bit sc, sr, fc, fr, nu, nd;
    if (rst) begin
      m_cnt = 0; m_ratio = clampn(int'(n_in)); m_cy = 1; m_rcnt = 0; m_fref = 1;
      m_pc = 0; m_pr = 0; m_up = 0; m_dn = 0; m_hiz = 1; m_p0 = 0; m_p1 = 0;
    end else begin
      sc = (t1 && t0) ? i1 : m_cy;
      sr = (t1 && t0) ? i0 : m_fref;
      fc = m_pc && !sc;
      fr = m_pr && !sr;
      nu = m_up || fc;
      nd = m_dn || fr;
      if (nu && nd) begin nu = 0; nd = 0; end
      m_hiz = t0 || !(nu || nd) || ((m_up || fc) && (m_dn || fr));
      m_up = nu; m_dn = nd;
      m_p0 = (t1 && !t0) ? m_fref : 1'b0;
      m_p1 = (t1 && !t0) ? m_cy : 1'b0;
      m_pc = sc; m_pr = sr;
      if (vt) begin
        if (m_cnt == m_ratio - 1) begin m_cnt = 0; m_ratio = clampn(int'(n_in)); end
        else m_cnt++;
        m_cy = (m_cnt < m_ratio / 2);
      end
      if (xt) begin
        m_rcnt = (m_rcnt == 31) ? 0 : m_rcnt + 1;
        m_fref = (m_rcnt < 16);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    model_update();
    chk(int'(cy), int'(m_cy), "R2 cy");
    chk(int'(fref), int'(m_fref), "R5 fref");
    chk(int'(up), int'(m_up), "R6 up");
    chk(int'(dn), int'(m_dn), "R7 dn");
    chk(int'(hiz), int'(m_hiz), "R9 cp_hiz");
    chk(int'(p0), int'(m_p0), "R10 p0");
    chk(int'(p1), int'(m_p1), "R10 p1");
    if (cy && !last_cy) rises.push_back(cyc);
    last_cy = cy;
    if (up) upcnt++;
    if (dn) dncnt++;
    if (!hiz) drivecnt++;
    vt = (vper != 0) && (cyc % vper == 0);
    xt = (xper != 0) && (cyc % xper == 0);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; run(3); rst = 1'b0;
  endtask

  initial begin
    int k;
    // R1 reset state
    n_in = 15'd300; vper = 1; xper = 1;
    do_reset();
    chk(int'(up), 0, "R1 up"); chk(int'(dn), 0, "R1 dn");
    chk(int'(hiz), 1, "R1 cp_hiz"); chk(int'(cy), 1, "R1 cy");
    chk(int'(fref), 1, "R1 fref"); chk(int'(p0) + int'(p1), 0, "R1 ports");
    rises.delete();
    run(1500);
    // R2 period equals N
    chk(rises[2] - rises[1], 300, "R2 period");
    // R4 reload only at terminal count
    run(37);
    n_in = 15'd400;
    k = rises.size();
    run(1000);
    chk(rises[k] - rises[k-1], 300, "R4 old period kept");
    chk(rises[k+1] - rises[k], 400, "R4 new period");
    // R3 clamp
    n_in = 15'd100;
    do_reset();
    rises.delete();
    run(800);
    chk(rises[1] - rises[0], 256, "R3 clamp");
    // Drifting phases, model-compared
    n_in = 15'd323; xper = 10;
    do_reset();
    run(2500);
    // R9 forced float
    t0 = 1'b1; step(); drivecnt = 0;
    run(600);
    chk(drivecnt, 0, "R9 float while t0");
    t0 = 1'b0;
    run(700);
    // R10 export
    t1 = 1'b1;
    run(700);
    t1 = 1'b0;
    run(20);
    // R11 inject: lead, lag, coincident
    t1 = 1'b1; t0 = 1'b1; i1 = 1'b1; i0 = 1'b1;
    do_reset();
    run(4);
    upcnt = 0; dncnt = 0;
    i1 = 1'b0; run(3); i0 = 1'b0; run(2);
    chk(upcnt, 3, "R11 R6 lead up width");
    chk(dncnt, 0, "R11 R6 no down on lead");
    i1 = 1'b1; i0 = 1'b1; run(3);
    upcnt = 0; dncnt = 0;
    i0 = 1'b0; run(2); i1 = 1'b0; run(2);
    chk(dncnt, 2, "R11 R7 lag down width");
    chk(upcnt, 0, "R11 R7 no up on lag");
    i1 = 1'b1; i0 = 1'b1; run(3);
    upcnt = 0; dncnt = 0;
    i1 = 1'b0; i0 = 1'b0; run(3);
    chk(upcnt + dncnt, 0, "R8 coincident falls");
    t1 = 1'b0; t0 = 1'b0;
    run(5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got %0d expected %0d cycles", 150000, cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule